// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 48-bit virtual address into a physical address by reading up to four levels of 8-byte translation entries from memory. The first table sits at a root base that the caller supplies with each request. At each level nine bits of the virtual address pick one entry. The entry either points to the next table or, at the last three levels, ends the walk with a page.

A request is accepted only while the walker is idle. The walker then works alone through a memory port that carries one transfer at a time. When it finds an intermediate entry whose accessed flag is clear, it writes that entry back with the flag set before it goes down a level. The walk ends with a one-cycle `done` pulse. Either the result outputs then hold the leaf entry, the page size, the physical address and the combined permissions, or the fault outputs hold the reason.

Entry bit positions used throughout are:

| Bit | Meaning |
|-----|---------|
| 0 | present |
| 1 | writable |
| 2 | user |
| 5 | accessed |
| 7 | large page |
| 12 | attribute bit of a large page |
| 51:12 | next-table or frame base |
| 62:52 | reserved |
| 63 | no-execute |

Top module: `ptw_walker`

## Requirements
- R1: If bits 63:47 of the request address are not all equal, the walk ends with `done`, `fault` and `gp_fault` high. No memory request is made.
- R2: Every table read goes to the table base (entry bits 51:12, or the root base at the top level) plus eight times the index. The index is virtual-address bits 47:39, 38:30, 29:21 and 20:12 for levels 3, 2, 1 and 0, so every address is 8-byte aligned.
- R3: An entry whose present bit is 0 ends the walk with a fault, and `fault_code` bits 0 and 2 are 0.
- R4: A level-3 entry with the large-page bit set ends the walk with a reserved-bit fault.
- R5: The large-page bit at level 2 ends the walk with a 1 GB page (`page_size`=2). At level 1 it ends the walk with a 2 MB page (`page_size`=1). A level-0 entry gives a 4 KB page (`page_size`=0). No further reads follow the leaf.
- R6: An intermediate entry with accessed clear is written back at the same address with bit 5 set, before the next level is read. An intermediate entry with accessed already set causes no write. The leaf is never written.
- R7: Entry bits 62:52 are reserved. Bit 63 is also reserved while `nx_en` is 0. Any reserved bit set gives a reserved-bit fault.
- R8: In a large-page leaf, the entry bits from 13 up to the page-offset width are reserved. Bit 12 is allowed.
- R9: `perm_nx` is the OR of bit 63 over all entries of the walk. `perm_user` is the AND of bit 2 and `perm_write` is the AND of bit 1 over the same entries.
- R10: `phys_addr` is the leaf base with the page-offset bits cleared, ORed with the virtual-address offset within the page.
- R11: On a table fault, `fault_code` is {fetch, reserved, write, present}. Bit 0 is set when the entry was present. Bit 1 is set for write access (`req_acc`=1). Bit 2 is set for a reserved-bit fault. Bit 3 is set for instruction fetch (`req_acc`=2).
- R12: `mem_req`, `mem_addr` and `mem_we` stay stable until `mem_ack`, and the walker waits in each step for as many cycles as the memory takes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a walk (taken when idle) |
| req_vaddr | input | 64 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| root_base | input | 64 | Root table base (bits 51:12 used) |
| nx_en | input | 1 | No-execute enabled; when 0, bit 63 is reserved |
| mem_req | output | 1 | Memory transfer pending |
| mem_we | output | 1 | Pending transfer is a write |
| mem_addr | output | 52 | Entry address |
| mem_wdata | output | 64 | Write-back data |
| mem_ack | input | 1 | Transfer complete; read data valid |
| mem_rdata | input | 64 | Read data |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle walk-complete pulse |
| fault | output | 1 | Walk ended in a fault |
| gp_fault | output | 1 | Fault was a non-canonical address |
| fault_code | output | 4 | Table-fault reason bits |
| leaf_entry | output | 64 | Final entry of a good walk |
| page_size | output | 2 | 0 = 4 KB, 1 = 2 MB, 2 = 1 GB |
| phys_addr | output | 52 | Translated address |
| perm_nx | output | 1 | Combined no-execute |
| perm_user | output | 1 | Combined user permission |
| perm_write | output | 1 | Combined write permission |

## Verification
The bench targets the points where a walk ends early, checking both the read count and the reported size:
- A 1 GB or 2 MB leaf that is treated as a table pointer shows up as an extra read.
- A large bit at the top level that is accepted shows up as a missing fault.

It sets large-page low bits one at a time and separately from the allowed attribute bit. This catches a mask that is one bit too wide (good pages rejected) or too narrow (bad pages accepted). It counts write-backs against the accessed flags, so a design that updates the leaf or skips an intermediate write is caught. It also runs a non-canonical address with bit 47 set, which catches a sign-extension check that is off by one bit. Permission folding and fault-code bit order are checked with restrictions placed at different levels, and a slow memory shows whether a step that does not wait for the acknowledge loses data.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int ENT_W  = 64;
    localparam int VA_W   = 48;
    localparam int PA_W   = 52;
    localparam int IDX_W  = 9;
    localparam int LVLS   = 4;
    localparam int PG_SH  = 12;
    localparam int LVL_W  = $clog2(LVLS);

    localparam int B_PRES  = 0;
    localparam int B_WR    = 1;
    localparam int B_USR   = 2;
    localparam int B_ACC   = 5;
    localparam int B_LARGE = 7;
    localparam int B_ATTR  = 12;
    localparam int B_NX    = 63;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WBACK
    } walk_st_e;

    typedef struct packed {
        logic nx;
        logic usr;
        logic wr;
    } perm_t;

    function automatic perm_t perm_fold(perm_t acc, perm_t cur);
        perm_t r;
        r.nx  = acc.nx | cur.nx;
        r.usr = acc.usr & cur.usr;
        r.wr  = acc.wr & cur.wr;
        return r;
    endfunction
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
    parameter int VA_BITS  = ptw_pkg::VA_W,
    parameter int PA_BITS  = ptw_pkg::PA_W,
    parameter int IDX_BITS = ptw_pkg::IDX_W,
    parameter int OFF_BITS = ptw_pkg::PG_SH,
    parameter int LV_BITS  = ptw_pkg::LVL_W
) (
    input  logic [VA_BITS-1:OFF_BITS]  va_hi,
    input  logic [LV_BITS-1:0]         lvl,
    input  logic [PA_BITS-1:OFF_BITS]  tbl,
    output logic [PA_BITS-1:0]         addr
);
    localparam int SCALE = 3;
    localparam int IDX_N = (VA_BITS - OFF_BITS) / IDX_BITS;

    logic [IDX_BITS-1:0] idx_sel [IDX_N];

    for (genvar g = 0; g < IDX_N; g++) begin : g_slice
        assign idx_sel[g] = va_hi[OFF_BITS + IDX_BITS*g +: IDX_BITS];
    end

    always_comb begin
        addr = {tbl, {(OFF_BITS-IDX_BITS-SCALE){1'b0}}, idx_sel[lvl], {SCALE{1'b0}}};
    end
endmodule

// File: rtl/ptw_entry_chk.sv
module ptw_entry_chk
    import ptw_pkg::*;
#(
    parameter int PA_BITS  = ptw_pkg::PA_W,
    parameter int IDX_BITS = ptw_pkg::IDX_W,
    parameter int OFF_BITS = ptw_pkg::PG_SH,
    parameter int LV_BITS  = ptw_pkg::LVL_W,
    parameter int TOP_LVL  = ptw_pkg::LVLS - 1
) (
    input  logic [ENT_W-1:0]          ent,
    input  logic [LV_BITS-1:0]        lvl,
    input  logic                      nx_en,
    output logic                      present,
    output logic                      rsvd,
    output logic                      leaf,
    output logic                      accessed,
    output perm_t                     perm,
    output logic [PA_BITS-1:OFF_BITS] next_tbl
);
    logic             large_leaf;
    logic [ENT_W-1:0] low_mask;
    int               sh;

    always_comb begin
        present    = ent[B_PRES];
        accessed   = ent[B_ACC];
        next_tbl   = ent[PA_BITS-1:OFF_BITS];
        perm.nx    = ent[B_NX];
        perm.usr   = ent[B_USR];
        perm.wr    = ent[B_WR];
        large_leaf = ent[B_LARGE] && (int'(lvl) != 0) && (int'(lvl) != TOP_LVL);
        leaf       = (lvl == '0) || large_leaf;
        sh         = OFF_BITS + IDX_BITS * int'(lvl);
        low_mask   = ((ENT_W'(1) << sh) - ENT_W'(1)) & ~((ENT_W'(1) << (B_ATTR + 1)) - ENT_W'(1));
        rsvd       = (|ent[ENT_W-2:PA_BITS])
                   | (!nx_en && ent[B_NX])
                   | ((int'(lvl) == TOP_LVL) && ent[B_LARGE])
                   | (large_leaf && |(ent & low_mask));
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int VA_BITS  = ptw_pkg::VA_W,
    parameter int PA_BITS  = ptw_pkg::PA_W,
    parameter int IDX_BITS = ptw_pkg::IDX_W,
    parameter int LEVELS   = ptw_pkg::LVLS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [63:0]        req_vaddr,
    input  logic [1:0]         req_acc,
    input  logic [63:0]        root_base,
    input  logic               nx_en,
    output logic               mem_req,
    output logic               mem_we,
    output logic [PA_BITS-1:0] mem_addr,
    output logic [63:0]        mem_wdata,
    input  logic               mem_ack,
    input  logic [63:0]        mem_rdata,
    output logic               busy,
    output logic               done,
    output logic               fault,
    output logic               gp_fault,
    output logic [3:0]         fault_code,
    output logic [63:0]        leaf_entry,
    output logic [1:0]         page_size,
    output logic [PA_BITS-1:0] phys_addr,
    output logic               perm_nx,
    output logic               perm_user,
    output logic               perm_write
);
    localparam int LV_BITS = $clog2(LEVELS);
    localparam int TOP     = LEVELS - 1;

    walk_st_e                 st;
    logic [LV_BITS-1:0]       lvl;
    logic [VA_BITS-1:0]       va_q;
    logic [1:0]               acc_q;
    logic [PA_BITS-1:PG_SH]   tbl_q;
    logic [63:0]              wb_q;
    perm_t                    pm_q;

    logic                     e_present, e_rsvd, e_leaf, e_acc;
    perm_t                    e_perm, pm_n;
    logic [PA_BITS-1:PG_SH]   e_next;
    logic [PA_BITS-1:0]       off_mask, pa_n;
    logic                     canon;

    ptw_addr_gen #(
        .VA_BITS(VA_BITS), .PA_BITS(PA_BITS), .IDX_BITS(IDX_BITS),
        .OFF_BITS(PG_SH), .LV_BITS(LV_BITS)
    ) u_addr (
        .va_hi (va_q[VA_BITS-1:PG_SH]),
        .lvl   (lvl),
        .tbl   (tbl_q),
        .addr  (mem_addr)
    );

    ptw_entry_chk #(
        .PA_BITS(PA_BITS), .IDX_BITS(IDX_BITS), .OFF_BITS(PG_SH),
        .LV_BITS(LV_BITS), .TOP_LVL(TOP)
    ) u_chk (
        .ent      (mem_rdata),
        .lvl      (lvl),
        .nx_en    (nx_en),
        .present  (e_present),
        .rsvd     (e_rsvd),
        .leaf     (e_leaf),
        .accessed (e_acc),
        .perm     (e_perm),
        .next_tbl (e_next)
    );

    always_comb begin
        canon     = (&req_vaddr[63:VA_BITS-1]) | ~(|req_vaddr[63:VA_BITS-1]);
        pm_n      = perm_fold(pm_q, e_perm);
        off_mask  = (PA_BITS'(1) << (PG_SH + IDX_BITS * int'(lvl))) - PA_BITS'(1);
        pa_n      = (mem_rdata[PA_BITS-1:0] & ~off_mask) | (PA_BITS'(va_q) & off_mask);
        mem_req   = (st == ST_READ) || (st == ST_WBACK);
        mem_we    = (st == ST_WBACK);
        mem_wdata = wb_q;
        busy      = (st != ST_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            lvl        <= '0;
            va_q       <= '0;
            acc_q      <= '0;
            tbl_q      <= '0;
            wb_q       <= '0;
            pm_q       <= '0;
            done       <= 1'b0;
            fault      <= 1'b0;
            gp_fault   <= 1'b0;
            fault_code <= '0;
            leaf_entry <= '0;
            page_size  <= '0;
            phys_addr  <= '0;
            perm_nx    <= 1'b0;
            perm_user  <= 1'b0;
            perm_write <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st)
                ST_IDLE: if (req_valid) begin
                    fault      <= 1'b0;
                    gp_fault   <= 1'b0;
                    fault_code <= '0;
                    va_q       <= req_vaddr[VA_BITS-1:0];
                    acc_q      <= req_acc;
                    if (!canon) begin
                        done     <= 1'b1;
                        fault    <= 1'b1;
                        gp_fault <= 1'b1;
                    end else begin
                        st    <= ST_READ;
                        lvl   <= LV_BITS'(TOP);
                        tbl_q <= root_base[PA_BITS-1:PG_SH];
                        pm_q  <= '{nx: 1'b0, usr: 1'b1, wr: 1'b1};
                    end
                end
                ST_READ: if (mem_ack) begin
                    if (!e_present || e_rsvd) begin
                        st         <= ST_IDLE;
                        done       <= 1'b1;
                        fault      <= 1'b1;
                        fault_code <= {acc_q == ACC_FETCH, e_present & e_rsvd,
                                       acc_q == ACC_WRITE, e_present};
                    end else if (e_leaf) begin
                        st         <= ST_IDLE;
                        done       <= 1'b1;
                        leaf_entry <= mem_rdata;
                        page_size  <= 2'(lvl);
                        phys_addr  <= pa_n;
                        perm_nx    <= pm_n.nx;
                        perm_user  <= pm_n.usr;
                        perm_write <= pm_n.wr;
                    end else begin
                        pm_q <= pm_n;
                        if (!e_acc) begin
                            wb_q <= mem_rdata | (64'd1 << B_ACC);
                            st   <= ST_WBACK;
                        end else begin
                            tbl_q <= e_next;
                            lvl   <= lvl - 1'b1;
                        end
                    end
                end
                ST_WBACK: if (mem_ack) begin
                    tbl_q <= wb_q[PA_BITS-1:PG_SH];
                    lvl   <= lvl - 1'b1;
                    st    <= ST_READ;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R2
    entry_align_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[2:0] == 3'b000));

    // R1
    gp_nomem_chk: assert property (@(posedge clk) disable iff (rst)
        (done && gp_fault) |-> (fault && !$past(mem_req)));

    // R6
    wb_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (mem_wdata[B_ACC] && mem_wdata[B_PRES]));

    // R11
    rsvd_code_chk: assert property (@(posedge clk) disable iff (rst)
        (done && fault_code[2]) |-> (fault && fault_code[0]));

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: tb/ptw_walker_bench.sv
module ptw_walker_bench;
    localparam logic [63:0] ROOT = 64'h1000;
    localparam logic [63:0] T2 = 64'h2000, T1 = 64'h3000, T0 = 64'h4000;
    localparam logic [63:0] FP = 64'h1, FW = 64'h2, FU = 64'h4, FA = 64'h20, FL = 64'h80;
    localparam logic [63:0] NXB = 64'h8000_0000_0000_0000;
    localparam logic [63:0] OK = FP | FW | FU;

    logic clk = 0, rst = 1;
    logic req_valid = 0, nx_en = 1;
    logic [63:0] req_vaddr = 0, root_base = ROOT;
    logic [1:0]  req_acc = 0;
    logic mem_req, mem_we, mem_ack = 0;
    logic [51:0] mem_addr;
    logic [63:0] mem_wdata, mem_rdata = 0;
    logic busy, done, fault, gp_fault, perm_nx, perm_user, perm_write;
    logic [3:0]  fault_code;
    logic [63:0] leaf_entry;
    logic [1:0]  page_size;
    logic [51:0] phys_addr;

    logic [63:0] mem [logic [51:0]];
    int rd_cnt = 0, wr_cnt = 0, lat = 0, wait_cnt = 0;
    int n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    ptw_walker u_ptw_walker (.*);

    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 0;
            wait_cnt = 0;
        end else if (mem_req) begin
            if (wait_cnt >= lat) begin
                mem_ack = 1;
                if (mem_we) begin
                    mem[mem_addr] = mem_wdata;
                    wr_cnt++;
                end else begin
                    mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 64'h0;
                    rd_cnt++;
                end
            end else wait_cnt++;
        end
    end

    task automatic chk(string r, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", r, act, exp);
        end
    endtask

    function automatic logic [51:0] ea(logic [63:0] base, logic [63:0] va, int l);
        logic [8:0] ix = va[12 + 9*l +: 9];
        return {base[51:12], 12'h0} + {40'h0, ix, 3'b000};
    endfunction

    function automatic logic [63:0] rd(logic [51:0] a);
        return mem.exists(a) ? mem[a] : 64'h0;
    endfunction

    task automatic build(logic [63:0] va, logic [63:0] e3, e2, e1, e0);
        mem.delete();
        mem[ea(ROOT, va, 3)] = e3;
        mem[ea(e3, va, 2)]   = e2;
        mem[ea(e2, va, 1)]   = e1;
        mem[ea(e1, va, 0)]   = e0;
    endtask

    task automatic walk(logic [63:0] va, logic [1:0] acc);
        bit seen = 0;
        rd_cnt = 0; wr_cnt = 0;
        @(negedge clk);
        req_vaddr = va; req_acc = acc; req_valid = 1;
        for (int k = 0; k < 500; k++) begin
            @(negedge clk);
            req_valid = 0;
            if (done) begin seen = 1; break; end
        end
        chk("walk ended", 64'(seen), 64'd1);
    endtask

    task automatic t_reset();
        chk("R12 reset mem_req", 64'(mem_req), 0);
        chk("R12 reset busy", 64'(busy), 0);
        chk("R3 reset fault", 64'(fault), 0);
    endtask

    task automatic t_4k(int latency);
        logic [63:0] va = 64'h0000_1234_5678_9ABC;
        logic [63:0] leaf = 64'h0ABC_D000 | OK;
        lat = latency;
        build(va, T2 | OK, T1 | OK, T0 | OK, leaf);
        walk(va, 0);
        chk("R10 4K phys", 64'(phys_addr), 64'h0ABC_DABC);
        chk("R5 4K size", 64'(page_size), 0);
        chk("R2 4K reads", 64'(rd_cnt), 4);
        chk("R6 writebacks", 64'(wr_cnt), 3);
        chk("R6 top entry flagged", rd(ea(ROOT, va, 3)), T2 | OK | FA);
        chk("R6 leaf untouched", rd(ea(T0, va, 0)), leaf);
        chk("R12 leaf out", leaf_entry, leaf);
        chk("R3 no fault", 64'(fault), 0);
        lat = 0;
    endtask

    task automatic t_acc_set();
        logic [63:0] va = 64'hFFFF_8765_4321_0FED;
        build(va, T2 | OK | FA, T1 | OK | FA, T0 | OK | FA, 64'h5_5555_5000 | OK);
        walk(va, 0);
        chk("R6 no write when set", 64'(wr_cnt), 0);
        chk("R1 high canonical ok", 64'(phys_addr), 64'h5_5555_5FED);
    endtask

    task automatic t_2m();
        logic [63:0] va = 64'h0000_0000_4013_5678;
        build(va, T2 | OK | FA, T1 | OK | FA, 64'h3FE0_0000 | 64'h1000 | OK | FL, 0);
        walk(va, 0);
        chk("R8 attr bit allowed", 64'(fault), 0);
        chk("R5 2M size", 64'(page_size), 1);
        chk("R5 2M reads", 64'(rd_cnt), 3);
        chk("R10 2M phys", 64'(phys_addr), 64'h3FF3_5678);
    endtask

    task automatic t_1g();
        logic [63:0] va = 64'h0000_0040_1234_5678;
        build(va, T2 | OK | FA, 64'h80_0000_0000 | OK | FL, 0, 0);
        walk(va, 0);
        chk("R5 1G size", 64'(page_size), 2);
        chk("R5 1G reads", 64'(rd_cnt), 2);
        chk("R10 1G phys", 64'(phys_addr), 64'h80_1234_5678);
    endtask

    task automatic t_large_low();
        logic [63:0] va = 64'h0000_0000_4013_5678;
        build(va, T2 | OK | FA, T1 | OK | FA, 64'h3FE1_0000 | OK | FL, 0);
        walk(va, 0);
        chk("R8 2M low bit fault", 64'(fault), 1);
        chk("R11 rsvd code", 64'(fault_code), 4'b0101);
        va = 64'h0000_0040_1234_5678;
        build(va, T2 | OK | FA, 64'h80_2000_0000 | OK | FL, 0, 0);
        walk(va, 0);
        chk("R8 1G bit29 code", 64'(fault_code), 4'b0101);
    endtask

    task automatic t_not_present();
        logic [63:0] va = 64'h0000_1234_5678_9ABC;
        build(va, T2 | OK | FA, T1 | OK | FA, T0 | FW, 0);
        walk(va, 1);
        chk("R3 np fault", 64'(fault), 1);
        chk("R11 np write code", 64'(fault_code), 4'b0010);
        chk("R3 np reads", 64'(rd_cnt), 3);
    endtask

    task automatic t_top_large();
        logic [63:0] va = 64'h0000_1234_5678_9ABC;
        build(va, T2 | OK | FA | FL, T1 | OK, T0 | OK, 64'h1000 | OK);
        walk(va, 0);
        chk("R4 top large code", 64'(fault_code), 4'b0101);
        chk("R4 top large reads", 64'(rd_cnt), 1);
    endtask

    task automatic t_nx();
        logic [63:0] va = 64'h0000_1234_5678_9ABC;
        build(va, T2 | OK | FA, T1 | OK | FA, T0 | OK | FA, 64'h7000 | OK | NXB);
        nx_en = 0;
        walk(va, 2);
        chk("R7 nx reserved fetch code", 64'(fault_code), 4'b1101);
        nx_en = 1;
        walk(va, 0);
        chk("R7 nx allowed", 64'(fault), 0);
        chk("R9 nx folded", 64'(perm_nx), 1);
        build(va, T2 | OK | FA, T1 | OK | FA, T0 | OK | FA, 64'h0080_0000_0000_7000 | OK);
        walk(va, 0);
        chk("R7 high bits reserved", 64'(fault_code), 4'b0101);
    endtask

    task automatic t_perm();
        logic [63:0] va = 64'h0000_1234_5678_9ABC;
        build(va, T2 | FP | FW | FA, T1 | OK | FA, T0 | FP | FU | FA, 64'h9000 | OK);
        walk(va, 0);
        chk("R9 user cleared high", 64'(perm_user), 0);
        chk("R9 write cleared mid", 64'(perm_write), 0);
        chk("R9 nx clear", 64'(perm_nx), 0);
    endtask

    task automatic t_noncanon();
        walk(64'h0000_8000_0000_0000, 0);
        chk("R1 gp flag", 64'(gp_fault), 1);
        chk("R1 no reads", 64'(rd_cnt), 0);
        walk(64'h7FFF_0000_0000_0000, 0);
        chk("R1 gp upper", 64'(gp_fault), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 0;
        t_4k(0);
        t_4k(3);
        t_acc_set();
        t_2m();
        t_1g();
        t_large_low();
        t_not_present();
        t_top_large();
        t_nx();
        t_perm();
        t_noncanon();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule